// File: doc/BRIEF.md
# SPI Bus Monitor

This block listens to a four-wire SPI link without driving it. The serial clock, the chip-select line and both data lines arrive asynchronously. The block brings them into the system clock domain and finds the serial clock edges by comparing the synchronized clock with a registered copy of it. It then shifts the master-to-slave and slave-to-master bits into two words side by side.

Each complete word is reported on a one-cycle valid strobe, with both words presented together. If chip select is released before a word is complete, the bits collected so far are still reported, with a flag that marks the word as partial.

Five configuration inputs set how the bus is read:

- clock idle level;
- sampling phase;
- bit order;
- word length (8 or 16 bits);
- chip-select polarity.

Configuration is expected to change only while chip select is inactive. The serial clock must be slower than a quarter of the system clock.

Top module: `spi_sniffer`

## Requirements
- R1: Bits are sampled on the rising serial clock edge when `cfg_cpol` equals `cfg_cpha` (idle low/first edge, idle high/second edge), and on the falling edge otherwise; `cfg_cpol`=1 means the clock idles high.
- R2: With `cfg_lsb_first`=0, the first bit of a word ends up in the most significant bit of the word (bit 7 for 8-bit words, bit 15 for 16-bit words).
- R3: With `cfg_lsb_first`=1, the first bit of a word ends up in bit 0 and later bits fill upward.
- R4: `cfg_wide`=0 selects 8-bit words, reported in bits 7:0 with bits 15:8 zero; `cfg_wide`=1 selects 16-bit words.
- R5: `cfg_sel_high`=0 treats `bus_sel` low as active; `cfg_sel_high`=1 treats it high as active.
- R6: Every completed word raises `word_valid` for exactly one cycle, with `mosi_word` and `miso_word` both holding the words decoded from that same transfer.
- R7: Serial clock edges seen while chip select is inactive change nothing. The bit count starts from zero each time chip select becomes active.
- R8: Releasing chip select after 1 to length-1 bits produces one `word_valid` pulse with `word_partial`=1. The received bits are right-aligned: under R2 the first bit is the most significant of them, and under R3 it is bit 0. Releasing chip select with no bits collected produces no pulse.
- R9: After reset, `word_valid` and `word_partial` are 0 and both words are zero.
- R10: Several words sent back to back within one chip-select window are each reported in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on first edge, 1: sample on second edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_wide | input | 1 | 0: 8-bit words, 1: 16-bit words |
| cfg_sel_high | input | 1 | 1: chip select active high |
| bus_sclk | input | 1 | Observed serial clock |
| bus_sel | input | 1 | Observed chip select |
| bus_mosi | input | 1 | Observed master-to-slave data |
| bus_miso | input | 1 | Observed slave-to-master data |
| mosi_word | output | 16 | Decoded master-to-slave word |
| miso_word | output | 16 | Decoded slave-to-master word |
| word_valid | output | 1 | One-cycle strobe for a reported word |
| word_partial | output | 1 | Set with the strobe when the word was cut short |

## Verification
The bench runs every one of the 32 configuration combinations with random, different words on the two data lines. This separates the two data paths, the two bit orders and the two sampling edges: sampling on the wrong edge or swapping the lines gives wrong words. Random chip-select windows carry one to three words, sometimes followed by a truncated word, which exercises back-to-back reporting and right alignment of partial words. Directed cases toggle the clock with chip select inactive and release chip select with no bits collected; in both, no word may be reported.

// File: rtl/spi_sniff_pkg.sv
// Shared helpers for the SPI bus monitor.
// Assumes nothing beyond standard SystemVerilog.
package spi_sniff_pkg;

    // Data line indices inside the packed line vectors.
    localparam int LINE_MOSI = 0;
    localparam int LINE_MISO = 1;
    localparam int NUM_LINES = 2;

    // Returns 1 when the sampling edge is the falling edge of the serial clock.
    function automatic logic sample_on_fall(input logic cpol, input logic cpha);
        return cpol ^ cpha;
    endfunction

endpackage

// File: rtl/sniff_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; reset value of every stage is zero.
module sniff_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift each stage from its predecessor (or the pins).
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sniff_edge.sv
// Finds serial clock edges and chip-select activity from synchronized lines.
// Assumes inputs are already in the clk domain. After reset, chip select
// must be seen inactive once before it is treated as active (arming).
module sniff_edge
    import spi_sniff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic sel_s,
    input  logic cfg_cpol,
    input  logic cfg_cpha,
    input  logic cfg_sel_high,
    output logic sample,
    output logic sel_act,
    output logic sel_end
);
    logic sclk_q;
    logic act_q;
    logic armed;
    logic act_raw;
    logic rise;
    logic fall;

    assign act_raw = cfg_sel_high ? sel_s : ~sel_s;
    assign sel_act = act_raw & armed;
    assign rise    = sclk_s & ~sclk_q;
    assign fall    = ~sclk_s & sclk_q;
    assign sample  = sel_act & (sample_on_fall(cfg_cpol, cfg_cpha) ? fall : rise);
    assign sel_end = act_q & ~sel_act;

    // Keep registered copies of the clock and the active state; arm on idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            act_q  <= 1'b0;
            armed  <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            act_q  <= sel_act;
            armed  <= armed | ~act_raw;
        end
    end
endmodule

// File: rtl/sniff_shift.sv
// Shift register for one observed data line, in either bit order.
// Assumes bit_idx is below MAX_BITS whenever shift is high.
module sniff_shift #(
    parameter int MAX_BITS = 16,
    parameter int CNT_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                zero,
    input  logic                shift,
    input  logic                bit_in,
    input  logic                lsb_first,
    input  logic [CNT_W-1:0]    bit_idx,
    output logic [MAX_BITS-1:0] word,
    output logic [MAX_BITS-1:0] word_next
);
    genvar i;
    generate
        for (i = 0; i < MAX_BITS; i++) begin : g_bit
            if (i == 0) begin : g_low
                // Bit 0 takes the new bit in both orders when it is the target.
                assign word_next[i] = lsb_first ? ((bit_idx == CNT_W'(i)) ? bit_in : word[i])
                                                : bit_in;
            end else begin : g_up
                // Upper bits: indexed insert (LSB first) or shift up (MSB first).
                assign word_next[i] = lsb_first ? ((bit_idx == CNT_W'(i)) ? bit_in : word[i])
                                                : word[i-1];
            end
        end
    endgenerate

    // Hold, clear or take the shifted value.
    always_ff @(posedge clk) begin
        if (!rst_n || zero) begin
            word <= '0;
        end else if (shift) begin
            word <= word_next;
        end
    end
endmodule

// File: rtl/spi_sniffer.sv
// Passive SPI monitor: decodes both data lines under run-time framing options
// and reports whole or truncated words with a one-cycle strobe.
// Assumes configuration changes only while chip select is inactive and the
// serial clock half period spans at least two system clocks.
module spi_sniffer
    import spi_sniff_pkg::*;
#(
    parameter int MAX_BITS    = 16,
    parameter int SHORT_BITS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic                cfg_lsb_first,
    input  logic                cfg_wide,
    input  logic                cfg_sel_high,
    input  logic                bus_sclk,
    input  logic                bus_sel,
    input  logic                bus_mosi,
    input  logic                bus_miso,
    output logic [MAX_BITS-1:0] mosi_word,
    output logic [MAX_BITS-1:0] miso_word,
    output logic                word_valid,
    output logic                word_partial
);
    localparam int CNT_W = $clog2(MAX_BITS + 1);
    localparam int IN_W  = 2 + NUM_LINES;

    logic [IN_W-1:0]      pins_s;
    logic                 sample;
    logic                 sel_act;
    logic                 sel_end;
    logic [CNT_W-1:0]     bit_cnt;
    logic [CNT_W-1:0]     len_m1;
    logic                 last;
    logic                 zero;
    logic [NUM_LINES-1:0] line_s;
    logic [MAX_BITS-1:0]  word     [NUM_LINES];
    logic [MAX_BITS-1:0]  word_nxt [NUM_LINES];

    sniff_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_miso, bus_mosi, bus_sel, bus_sclk}),
        .sync_out (pins_s)
    );

    assign line_s = pins_s[IN_W-1:2];

    sniff_edge i_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_s       (pins_s[0]),
        .sel_s        (pins_s[1]),
        .cfg_cpol     (cfg_cpol),
        .cfg_cpha     (cfg_cpha),
        .cfg_sel_high (cfg_sel_high),
        .sample       (sample),
        .sel_act      (sel_act),
        .sel_end      (sel_end)
    );

    assign len_m1 = cfg_wide ? CNT_W'(MAX_BITS - 1) : CNT_W'(SHORT_BITS - 1);
    assign last   = sample && (bit_cnt >= len_m1);
    assign zero   = ~sel_act | last;

    genvar l;
    generate
        for (l = 0; l < NUM_LINES; l++) begin : g_line
            sniff_shift #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) i_shift (
                .clk       (clk),
                .rst_n     (rst_n),
                .zero      (zero),
                .shift     (sample),
                .bit_in    (line_s[l]),
                .lsb_first (cfg_lsb_first),
                .bit_idx   (bit_cnt),
                .word      (word[l]),
                .word_next (word_nxt[l])
            );
        end
    endgenerate

    // Count bits inside the active window; idle or completion returns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_act) begin
            bit_cnt <= '0;
        end else if (sample) begin
            bit_cnt <= last ? '0 : bit_cnt + 1'b1;
        end
    end

    // Report a finished word, or a truncated one when chip select drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mosi_word    <= '0;
            miso_word    <= '0;
            word_valid   <= 1'b0;
            word_partial <= 1'b0;
        end else begin
            word_valid   <= 1'b0;
            word_partial <= 1'b0;
            if (last) begin
                mosi_word  <= word_nxt[LINE_MOSI];
                miso_word  <= word_nxt[LINE_MISO];
                word_valid <= 1'b1;
            end else if (sel_end && bit_cnt != '0) begin
                mosi_word    <= word[LINE_MOSI];
                miso_word    <= word[LINE_MISO];
                word_valid   <= 1'b1;
                word_partial <= 1'b1;
            end
        end
    end

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    a_r8_partial_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        word_partial |-> word_valid);

    a_r8_partial_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        word_partial |-> !$past(sel_act));

    a_r7_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |=> (bit_cnt == '0));

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < CNT_W'(MAX_BITS));
endmodule

// File: tb/test_spi_sniffer.sv
module test_spi_sniffer;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;
    localparam int MAXEV      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
    logic        cfg_wide = 1'b0, cfg_sel_high = 1'b0;
    logic        bus_sclk = 1'b0, bus_sel = 1'b1, bus_mosi = 1'b0, bus_miso = 1'b0;
    logic [15:0] mosi_word, miso_word;
    logic        word_valid, word_partial;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] ev_mo [MAXEV];
    logic [15:0] ev_mi [MAXEV];
    logic        ev_pt [MAXEV];
    int          ev_n = 0;
    logic [15:0] ex_mo [MAXEV];
    logic [15:0] ex_mi [MAXEV];
    logic        ex_pt [MAXEV];
    int          ex_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sniffer i_spi_sniffer (
        .clk(clk), .rst_n(rst_n),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_wide(cfg_wide), .cfg_sel_high(cfg_sel_high),
        .bus_sclk(bus_sclk), .bus_sel(bus_sel), .bus_mosi(bus_mosi), .bus_miso(bus_miso),
        .mosi_word(mosi_word), .miso_word(miso_word),
        .word_valid(word_valid), .word_partial(word_partial)
    );

    // Record every reported word away from the active edge.
    always @(negedge clk) begin
        if (rst_n && word_valid && ev_n < MAXEV) begin
            ev_mo[ev_n] = mosi_word;
            ev_mi[ev_n] = miso_word;
            ev_pt[ev_n] = word_partial;
            ev_n++;
        end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int cur_len();
        return cfg_wide ? 16 : 8;
    endfunction

    // Bit sent in position i of a word (R2/R3 ordering).
    function automatic logic bit_at(input logic [15:0] w, input int i, input int len, input logic lsb);
        return lsb ? w[i] : w[len-1-i];
    endfunction

    // Expected right-aligned value after k bits of word w (R8).
    function automatic logic [15:0] exp_part(input logic [15:0] w, input int k, input int len, input logic lsb);
        return lsb ? (w & 16'((32'd1 << k) - 1)) : (w >> (len - k));
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Drive one bit on both lines, honouring clock idle level and phase (R1).
    task automatic send_bit(input logic mo, input logic mi);
        if (!cfg_cpha) begin
            bus_mosi = mo; bus_miso = mi;
            wait_clk(HALF_SCK);
            bus_sclk = ~cfg_cpol;
            wait_clk(HALF_SCK);
            bus_sclk = cfg_cpol;
        end else begin
            bus_sclk = ~cfg_cpol;
            bus_mosi = mo; bus_miso = mi;
            wait_clk(HALF_SCK);
            bus_sclk = cfg_cpol;
            wait_clk(HALF_SCK);
        end
    endtask

    task automatic set_cfg(input logic [4:0] c);
        bus_sel = ~cfg_sel_high;
        wait_clk(6);
        {cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_wide, cfg_sel_high} = c;
        bus_sel  = ~cfg_sel_high;
        bus_sclk = cfg_cpol;
        wait_clk(6);
    endtask

    // One chip-select window: nwords full words then an optional partial word.
    task automatic window(input int nwords, input int pbits);
        int len = cur_len();
        ev_n = 0; ex_n = 0;
        bus_sel = cfg_sel_high;
        wait_clk(HALF_SCK);
        for (int w = 0; w < nwords; w++) begin
            logic [15:0] mo = 16'($urandom) & 16'((32'd1 << len) - 1);
            logic [15:0] mi = 16'($urandom) & 16'((32'd1 << len) - 1);
            for (int i = 0; i < len; i++)
                send_bit(bit_at(mo, i, len, cfg_lsb_first), bit_at(mi, i, len, cfg_lsb_first));
            ex_mo[ex_n] = mo; ex_mi[ex_n] = mi; ex_pt[ex_n] = 1'b0; ex_n++;
        end
        if (pbits > 0) begin
            logic [15:0] mo = 16'($urandom) & 16'((32'd1 << len) - 1);
            logic [15:0] mi = 16'($urandom) & 16'((32'd1 << len) - 1);
            for (int i = 0; i < pbits; i++)
                send_bit(bit_at(mo, i, len, cfg_lsb_first), bit_at(mi, i, len, cfg_lsb_first));
            ex_mo[ex_n] = exp_part(mo, pbits, len, cfg_lsb_first);
            ex_mi[ex_n] = exp_part(mi, pbits, len, cfg_lsb_first);
            ex_pt[ex_n] = 1'b1; ex_n++;
        end
        wait_clk(HALF_SCK);
        bus_sel = ~cfg_sel_high;
        wait_clk(8);
    endtask

    task automatic compare(input string tag);
        check_eq({tag, " R10 word count"}, 32'(ev_n), 32'(ex_n));
        for (int i = 0; i < ex_n && i < ev_n; i++) begin
            check_eq({tag, " R6 mosi"}, 32'(ev_mo[i]), 32'(ex_mo[i]));
            check_eq({tag, " R6 miso"}, 32'(ev_mi[i]), 32'(ex_mi[i]));
            check_eq({tag, " R8 partial flag"}, 32'(ev_pt[i]), 32'(ex_pt[i]));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait_clk(150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        string tag;
        void'($urandom(32'h5EED_0042));
        wait_clk(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check_eq("R9 valid after reset", 32'(word_valid), 32'd0);
        check_eq("R9 partial after reset", 32'(word_partial), 32'd0);
        check_eq("R9 mosi after reset", 32'(mosi_word), 32'd0);
        check_eq("R9 miso after reset", 32'(miso_word), 32'd0);
        wait_clk(6);

        // R7: clock edges while chip select inactive are ignored.
        set_cfg(5'b00000);
        ev_n = 0;
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
        wait_clk(8);
        check_eq("R7 no word while inactive", 32'(ev_n), 32'd0);
        window(1, 0);
        compare("R7 after inactive toggles");

        // R8: release with no bits reports nothing.
        window(0, 0);
        check_eq("R8 empty window", 32'(ev_n), 32'd0);

        // R8: partial words in both orders, then count restarts (R7).
        set_cfg(5'b00010);
        window(0, 3);
        compare("R8 R2 partial msb-first wide");
        set_cfg(5'b00100);
        window(0, 5);
        compare("R8 R3 partial lsb-first narrow");
        window(1, 0);
        compare("R7 restart after partial");

        // R1 R2 R3 R4 R5 R10: every configuration with random words.
        for (int c = 0; c < 32; c++) begin
            set_cfg(5'(c));
            for (int r = 0; r < 2; r++) begin
                int nw = 1 + int'($urandom % 3);
                int pb = ($urandom % 3 == 0) ? 1 + int'($urandom % (cur_len() - 1)) : 0;
                tag = $sformatf("R1 R4 R5 cfg=%b %s", 5'(c), cfg_lsb_first ? "R3" : "R2");
                window(nw, pb);
                compare(tag);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule